// File: doc/BRIEF.md
# T1 Framing-Bit Generator

This block sits in the transmit path of a T1 line and rewrites the single framing-bit slot at the head of every 193-bit frame. The serial stream arrives one bit per clock, with a strobe that marks the framing-bit position. Every other bit passes through untouched, delayed by one output register.

Two multiframe formats are supported. In the 12-frame superframe, every framing slot carries a fixed alignment pattern. In the 24-frame extended superframe, three sources share the framing slots. Odd frames carry a data-link bit that an external arbiter supplies. Frames 2, 6, 10, 14, 18 and 22 carry the CRC-6 of the previous multiframe. Frames 4, 8, 12, 16, 20 and 24 carry the alignment pattern. Each source has its own bypass, which lets the incoming bit through. A master bypass does the same for every framing slot. A select input picks which framing-bit value the CRC uses: the T1 rule or the J1 rule.

The block also emits a strobe on each framing bit and a strobe on the framing bit of frame 1. A change of format select is held back until the running multiframe is complete.

Top module: `t1_fbit_inserter`

## Requirements
- R1: In superframe mode (cfg_esf = 0 when latched), the framing bits of frames 1 to 12 are 1,0,0,0,1,1,0,1,1,1,0,0.
- R2: In extended superframe mode, the framing bits of frames 4, 8, 12, 16, 20 and 24 are 0,0,1,0,1,1 in that order.
- R3: In extended superframe mode without CRC bypass, frames 2, 6, 10, 14, 18 and 22 carry bits 5 down to 0 of a CRC-6. The CRC uses generator x^6+x+1, starts from zero and is fed MSB-first serially. It covers all 4632 bits of the previous multiframe as transmitted. When the previous multiframe was not a complete extended superframe, which covers the first one after reset or after a superframe, the value is 000000.
- R4: With cfg_j1_crc = 0, every framing-bit position enters the CRC as logic 1. With cfg_j1_crc = 1, the framing bit actually transmitted enters the CRC.
- R5: With cfg_crc_byp = 1, the CRC slots carry the incoming bit unchanged.
- R6: In extended superframe mode, odd frames carry dl_bit. With cfg_dl_byp = 1, they carry the incoming bit instead.
- R7: With cfg_fbit_byp = 1, every framing slot in either format carries the incoming bit.
- R8: Every bit that is not a framing bit appears on dout unchanged, one clock after it is presented on din.
- R9: fbit_mark is high for exactly the one clock in which a framing bit is on dout. mf_start is high for one clock, together with the framing bit of frame 1.
- R10: The first frame_start after reset is frame 1 and loads cfg_esf. Later changes of cfg_esf take effect only at the next frame 1.
- R11: While reset is active, dout, mf_start and fbit_mark are 0. Before the first frame_start, nothing is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Incoming serial bit |
| frame_start | input | 1 | High on the framing-bit position of each frame |
| dl_bit | input | 1 | Data-link bit value from the arbiter |
| cfg_esf | input | 1 | 1 = 24-frame extended superframe, 0 = 12-frame superframe |
| cfg_fbit_byp | input | 1 | Pass every framing slot through unchanged |
| cfg_crc_byp | input | 1 | Pass CRC slots through unchanged |
| cfg_dl_byp | input | 1 | Pass data-link slots through unchanged |
| cfg_j1_crc | input | 1 | CRC variant: 0 = T1, 1 = J1 |
| dout | output | 1 | Serial stream with framing bits inserted |
| fbit_mark | output | 1 | High while dout holds a framing bit |
| mf_start | output | 1 | High while dout holds the framing bit of frame 1 |

## Verification
The hardest state to reach from the ports is a CRC slot whose value depends on a full, correct multiframe. Reaching it takes 4632 bits of varied data, and the CRC is only visible one multiframe later. When the J1 variant is selected, the transmitted framing bits themselves feed the CRC. The stimulus runs a pseudo-random payload and data-link stream for two or three complete extended superframes per configuration, so every CRC slot of the second and third multiframes is compared with an independently accumulated CRC. A directed sequence flips the format select in the middle of a multiframe in both directions. This confirms the deferred switch and the all-zero CRC of the first extended superframe after a superframe.

// File: rtl/t1fb_pkg.sv
package t1fb_pkg;

  localparam int SF_FRAMES  = 12;
  localparam int ESF_FRAMES = 24;
  localparam int CRC_W      = 6;

  // bit i holds the framing bit of superframe frame i+1
  localparam logic [11:0] SF_ALIGN  = 12'b0011_1011_0001;
  // bit k holds the alignment bit of extended frame 4*(k+1)
  localparam logic [5:0]  ESF_ALIGN = 6'b11_0100;
  // x^6 + x + 1 without the x^6 term
  localparam logic [CRC_W-1:0] CRC_POLY = 6'b00_0011;

  typedef enum logic [1:0] {
    SLOT_ALIGN,
    SLOT_CRC,
    SLOT_LINK
  } slot_e;

  function automatic logic [CRC_W-1:0] crc6_next(input logic [CRC_W-1:0] c,
                                                 input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic slot_e slot_kind(input logic esf, input logic [1:0] phase);
    if (!esf) return SLOT_ALIGN;
    case (phase)
      2'b01:   return SLOT_CRC;
      2'b11:   return SLOT_ALIGN;
      default: return SLOT_LINK;
    endcase
  endfunction

  function automatic logic align_bit(input logic esf, input logic [4:0] idx);
    return esf ? ESF_ALIGN[idx[4:2]] : SF_ALIGN[idx[3:0]];
  endfunction

  // group 0 (frame 2) sends the MSB
  function automatic logic crc_pick(input logic [CRC_W-1:0] h, input logic [2:0] grp);
    return h[3'd5 - grp];
  endfunction

endpackage

// File: rtl/t1fb_sequencer.sv
module t1fb_sequencer #(
  parameter int SF_FRAMES  = t1fb_pkg::SF_FRAMES,
  parameter int ESF_FRAMES = t1fb_pkg::ESF_FRAMES,
  parameter int IDX_W      = $clog2(ESF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             cfg_esf,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cur_esf,
  output logic             mf_begin,
  output logic             prev_full
);

  localparam logic [IDX_W-1:0] SF_LAST  = IDX_W'(SF_FRAMES - 1);
  localparam logic [IDX_W-1:0] ESF_LAST = IDX_W'(ESF_FRAMES - 1);

  logic [IDX_W-1:0] fcnt;
  logic             esf_act;
  logic             started;
  logic [IDX_W-1:0] last;

  assign last      = esf_act ? ESF_LAST : SF_LAST;
  assign mf_begin  = frame_start && (!started || fcnt == last);
  assign cur_esf   = mf_begin ? cfg_esf : esf_act;
  assign prev_full = started && esf_act;

  always_comb begin
    if (!frame_start)  cur_idx = fcnt;
    else if (mf_begin) cur_idx = '0;
    else               cur_idx = fcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt    <= '0;
      esf_act <= 1'b0;
      started <= 1'b0;
    end else if (frame_start) begin
      fcnt    <= cur_idx;
      esf_act <= cur_esf;
      started <= 1'b1;
    end
  end

  // R10: the active format only moves on a multiframe boundary
  a_r10_fmt_held: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_begin |=> $stable(esf_act));

  // R1: the frame index never leaves the active format's range
  a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= last);

endmodule

// File: rtl/t1fb_crc6.sv
module t1fb_crc6 #(
  parameter int CRC_W = t1fb_pkg::CRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mf_begin,
  input  logic             prev_full,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_hold
);
  import t1fb_pkg::*;

  logic [CRC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      crc_hold <= '0;
    end else if (mf_begin) begin
      crc_hold <= prev_full ? acc : '0;
      acc      <= crc6_next('0, bit_in);
    end else begin
      acc      <= crc6_next(acc, bit_in);
    end
  end

  // R3: the sent CRC only changes at a multiframe boundary
  a_r3_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_begin |=> $stable(crc_hold));

  // R3: a boundary after an incomplete multiframe loads zero
  a_r3_zero_after_partial: assert property (@(posedge clk) disable iff (!rst_n)
    mf_begin && !prev_full |=> crc_hold == '0);

endmodule

// File: rtl/t1fb_fbit_mux.sv
module t1fb_fbit_mux #(
  parameter int IDX_W = 5,
  parameter int CRC_W = t1fb_pkg::CRC_W
) (
  input  logic             frame_start,
  input  logic             din,
  input  logic             dl_bit,
  input  logic             cfg_fbit_byp,
  input  logic             cfg_crc_byp,
  input  logic             cfg_dl_byp,
  input  logic             cur_esf,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [CRC_W-1:0] crc_hold,
  output logic             out_bit
);
  import t1fb_pkg::*;

  slot_e slot;
  logic  fbit_val;

  assign slot = slot_kind(cur_esf, cur_idx[1:0]);

  always_comb begin
    if (cfg_fbit_byp) begin
      fbit_val = din;
    end else begin
      case (slot)
        SLOT_CRC:  fbit_val = cfg_crc_byp ? din : crc_pick(crc_hold, cur_idx[4:2]);
        SLOT_LINK: fbit_val = cfg_dl_byp ? din : dl_bit;
        default:   fbit_val = align_bit(cur_esf, cur_idx);
      endcase
    end
  end

  assign out_bit = frame_start ? fbit_val : din;

endmodule

// File: rtl/t1_fbit_inserter.sv
module t1_fbit_inserter #(
  parameter int SF_FRAMES  = t1fb_pkg::SF_FRAMES,
  parameter int ESF_FRAMES = t1fb_pkg::ESF_FRAMES,
  parameter int CRC_W      = t1fb_pkg::CRC_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic frame_start,
  input  logic dl_bit,
  input  logic cfg_esf,
  input  logic cfg_fbit_byp,
  input  logic cfg_crc_byp,
  input  logic cfg_dl_byp,
  input  logic cfg_j1_crc,
  output logic dout,
  output logic fbit_mark,
  output logic mf_start
);

  localparam int IDX_W = $clog2(ESF_FRAMES);

  logic [IDX_W-1:0] cur_idx;
  logic             cur_esf;
  logic             mf_begin;
  logic             prev_full;
  logic [CRC_W-1:0] crc_hold;
  logic             out_bit;
  logic             crc_feed;
  logic             primed;

  t1fb_sequencer #(
    .SF_FRAMES (SF_FRAMES),
    .ESF_FRAMES(ESF_FRAMES),
    .IDX_W     (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .cfg_esf    (cfg_esf),
    .cur_idx    (cur_idx),
    .cur_esf    (cur_esf),
    .mf_begin   (mf_begin),
    .prev_full  (prev_full)
  );

  t1fb_fbit_mux #(
    .IDX_W(IDX_W),
    .CRC_W(CRC_W)
  ) u_mux (
    .frame_start (frame_start),
    .din         (din),
    .dl_bit      (dl_bit),
    .cfg_fbit_byp(cfg_fbit_byp),
    .cfg_crc_byp (cfg_crc_byp),
    .cfg_dl_byp  (cfg_dl_byp),
    .cur_esf     (cur_esf),
    .cur_idx     (cur_idx),
    .crc_hold    (crc_hold),
    .out_bit     (out_bit)
  );

  // T1 counts framing positions as 1, J1 uses what is sent
  assign crc_feed = (frame_start && !cfg_j1_crc) ? 1'b1 : out_bit;

  t1fb_crc6 #(
    .CRC_W(CRC_W)
  ) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .mf_begin (mf_begin),
    .prev_full(prev_full),
    .bit_in   (crc_feed),
    .crc_hold (crc_hold)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout      <= 1'b0;
      fbit_mark <= 1'b0;
      mf_start  <= 1'b0;
      primed    <= 1'b0;
    end else begin
      dout      <= out_bit;
      fbit_mark <= frame_start;
      mf_start  <= mf_begin;
      primed    <= 1'b1;
    end
  end

  // R9: the multiframe strobe only sits on a framing bit
  a_r9_mf_on_fbit: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> fbit_mark);

  // R9: the multiframe strobe lasts one clock
  a_r9_mf_single: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |=> !mf_start);

  // R8: payload bits come through one clock later
  a_r8_payload_pass: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !fbit_mark |-> dout == $past(din));

  // R7: master bypass leaves framing bits untouched
  a_r7_fbit_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    primed && fbit_mark && $past(cfg_fbit_byp) |-> dout == $past(din));

endmodule

// File: tb/test_t1_fbit_inserter.sv
module test_t1_fbit_inserter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0, frame_start = 1'b0, dl_bit = 1'b0;
  logic cfg_esf = 1'b0, cfg_fbit_byp = 1'b0, cfg_crc_byp = 1'b0;
  logic cfg_dl_byp = 1'b0, cfg_j1_crc = 1'b0;
  logic dout, fbit_mark, mf_start;

  always #10 clk = ~clk;

  t1_fbit_inserter i_t1_fbit_inserter (
    .clk(clk), .rst_n(rst_n), .din(din), .frame_start(frame_start),
    .dl_bit(dl_bit), .cfg_esf(cfg_esf), .cfg_fbit_byp(cfg_fbit_byp),
    .cfg_crc_byp(cfg_crc_byp), .cfg_dl_byp(cfg_dl_byp), .cfg_j1_crc(cfg_j1_crc),
    .dout(dout), .fbit_mark(fbit_mark), .mf_start(mf_start)
  );

  typedef struct packed {
    logic [1:0] n_mf;    // runs of 24 frames
    logic [2:0] exp_mf;  // expected mf_start pulses (R9)
    logic esf, fbyp, cbyp, dbyp, j1;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd2, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd2, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd3, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{2'd2, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'd2, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{2'd2, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd2, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd2, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  localparam bit SF_PAT  [12] = '{1,0,0,0,1,1,0,1,1,1,0,0};
  localparam bit ESF_PAT [6]  = '{0,0,1,0,1,1};

  int checks = 0, failures = 0, mf_seen = 0;
  int bframe = 0;
  bit besf = 1'b0, bprevfull = 1'b0;
  logic [5:0] bacc = '0, bhold = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic exp_dout, exp_mf, exp_mark;
  bit have_exp = 1'b0;
  string exp_tag = "", ctx = "";

  function automatic logic [5:0] tb_crc(input logic [5:0] c, input logic b);
    logic [6:0] t;
    t = {c, 1'b0};
    if (c[5] ^ b) t = t ^ 7'b100_0011;
    return t[5:0];
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic predict(input logic fs);
    logic out, fval, feed;
    bit mfb;
    logic [2:0] grp;
    mfb = 1'b0;
    fval = 1'b0;
    if (fs) begin
      if (bframe == 0 || bframe == (besf ? 24 : 12)) begin
        mfb = 1'b1;
        bprevfull = (bframe != 0) && besf;
        besf = cfg_esf;
        bframe = 1;
      end else bframe++;
      if (cfg_fbit_byp) begin
        fval = din; exp_tag = "R7";
      end else if (!besf) begin
        fval = SF_PAT[bframe-1]; exp_tag = "R1";
      end else if (bframe % 2 == 1) begin
        fval = cfg_dl_byp ? din : dl_bit; exp_tag = "R6";
      end else if (bframe % 4 == 0) begin
        fval = ESF_PAT[bframe/4 - 1]; exp_tag = "R2";
      end else begin
        grp = 3'(5 - (bframe - 2) / 4);
        fval = cfg_crc_byp ? din : bhold[grp];
        exp_tag = cfg_crc_byp ? "R5" : (cfg_j1_crc ? "R4" : "R3");
      end
      out = fval;
    end else begin
      out = din;
      exp_tag = (bframe == 0) ? "R11" : "R8";
    end
    feed = (fs && !cfg_j1_crc) ? 1'b1 : out;
    if (mfb) begin
      bhold = bprevfull ? bacc : 6'd0;
      bacc  = tb_crc(6'd0, feed);
    end else bacc = tb_crc(bacc, feed);
    exp_dout = out;
    exp_mf   = mfb;
    exp_mark = fs;
    exp_tag  = {ctx, exp_tag};
  endtask

  task automatic step(input logic fs);
    @(negedge clk);
    if (have_exp) begin
      chk(exp_tag, "dout", dout, exp_dout);
      chk({ctx, "R9"}, "fbit_mark", fbit_mark, exp_mark);
      chk({ctx, "R9"}, "mf_start", mf_start, exp_mf);
      if (mf_start) mf_seen++;
    end
    din = lfsr[0];
    dl_bit = lfsr[7];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    frame_start = fs;
    predict(fs);
    have_exp = 1'b1;
  endtask

  task automatic run_frames(input int nf);
    for (int f = 0; f < nf; f++)
      for (int b = 0; b < 193; b++) step(b == 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frame_start = 1'b0; din = 1'b1; have_exp = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "dout in reset", dout, 1'b0);
    chk("R11", "mf_start in reset", mf_start, 1'b0);
    chk("R11", "fbit_mark in reset", fbit_mark, 1'b0);
    bframe = 0; besf = 1'b0; bacc = '0; bhold = '0; bprevfull = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // table of configurations, each run from reset
    for (int v = 0; v < 8; v++) begin
      cfg_esf = VECS[v].esf; cfg_fbit_byp = VECS[v].fbyp;
      cfg_crc_byp = VECS[v].cbyp; cfg_dl_byp = VECS[v].dbyp;
      cfg_j1_crc = VECS[v].j1;
      ctx = "";
      do_reset();
      for (int k = 0; k < 6; k++) step(1'b0);   // R11: no insertion yet
      mf_seen = 0;
      run_frames(int'(VECS[v].n_mf) * 24);
      step(1'b0);
      chk("R9", "mf_start pulse count", 1'b1, mf_seen == int'(VECS[v].exp_mf));
      if (mf_seen != int'(VECS[v].exp_mf))
        $display("  (R9 pulses seen=%0d expected=%0d)", mf_seen, VECS[v].exp_mf);
    end

    // R10: format switch deferred to the boundary, both directions
    cfg_esf = 1'b0; cfg_fbit_byp = 1'b0; cfg_crc_byp = 1'b0;
    cfg_dl_byp = 1'b0; cfg_j1_crc = 1'b0;
    ctx = "R10/";
    do_reset();
    run_frames(4);
    cfg_esf = 1'b1;          // mid superframe
    run_frames(8);           // still superframe to frame 12
    run_frames(48);          // first ESF carries zero CRC, second real CRC
    run_frames(9);
    cfg_esf = 1'b0;          // mid extended superframe
    run_frames(15);
    run_frames(12);
    step(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule